// File: doc/BRIEF.md
# DRAM Refresh and Self-Refresh Scheduler

This block sits next to the access sequencer of an asynchronous DRAM controller and keeps the array refreshed. An interval timer counts clock cycles and produces one refresh obligation per interval. The obligations are counted up to a small cap, so a refresh delayed by the arbiter is made up later and not lost. Each obligation raises a request to the bus arbiter. Once the grant arrives, the block drives the row and column strobes (active low) through one refresh cycle. In CAS-before-RAS mode the column strobe falls first and no address is driven, because the device supplies the row from its own counter. In RAS-only mode the column strobe stays high and the block drives a row address taken from its own wrapping row counter.

A power manager can send a sleep pulse. The block requests the bus, and once granted it starts a CAS-before-RAS cycle and holds both strobes low. After the configured entry time the device is in self-refresh, and the block reports this. A wake pulse releases both strobes, and they stay high for the configured exit time. In CAS-before-RAS mode normal operation then resumes at once, with the interval timer restarted. In RAS-only mode the block first refreshes every row in one burst without asking for a new grant.

The request/grant pair is the only handshake. The grant is looked at only while the block is idle and requesting. The request stays high for as long as the block owns the strobes, which includes the whole of self-refresh and the exit burst.

Top module: `dram_refresh_sched`

## Requirements
- R1: During reset and right after it, ras_n and cas_n are high, addr_oe is low, ref_req is low, in_sr is low, ready is high and row_addr is 0.
- R2: Counting from the first clock edge after reset, ref_req rises after exactly INTERVAL edges. The timer keeps counting while a request waits for its grant.
- R3: Unserved intervals are counted up to PEND_MAX and no further. Each granted refresh retires one of them, so after a long wait without a grant exactly PEND_MAX refresh cycles follow before ref_req drops.
- R4: The strobes never move before a grant. The grant is taken only when ref_req is high, and ref_req stays high through every cycle the block owns.
- R5: When ras_only is 0, a refresh cycle has cas_n low for T_CSR cycles and then ras_n low with cas_n low for T_RAS cycles. Both strobes are then high for T_RP cycles, and addr_oe stays low throughout.
- R6: When ras_only is 1, a refresh cycle holds cas_n high and ras_n low for T_RAS cycles with addr_oe high and row_addr equal to the row counter. The counter then advances by one and wraps from ROWS-1 to 0.
- R7: A sleep pulse raises ref_req. After the grant, cas_n falls first and ras_n follows T_CSR cycles later, whatever ras_only is. in_sr rises once ras_n has been low for T_RASS cycles, and ready is low from the first strobe cycle onward.
- R8: While in_sr is high both strobes stay low and no interval-driven refresh runs. A wake pulse that arrives before the entry time has passed is held until ras_n has been low for exactly T_RASS cycles.
- R9: After a wake, both strobes stay high for T_RPS cycles before any other strobe activity, and ready stays low during that time.
- R10: When ras_only is 0, the block goes idle right after the exit time with ready high, no pending refresh and the timer restarted, so ref_req rises INTERVAL cycles later. When ras_only is 1, the block runs ROWS back-to-back RAS-only cycles with no grant, keeping ready low until the last precharge ends.
- R11: A wake pulse outside self-refresh has no effect, and a sleep pulse during self-refresh has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_only | input | 1 | Refresh method: 0 CAS-before-RAS distributed, 1 RAS-only with internal row counter |
| sleep_req | input | 1 | One-cycle pulse asking for self-refresh entry |
| wake_req | input | 1 | One-cycle pulse asking for self-refresh exit |
| ref_gnt | input | 1 | Arbiter grant, taken while idle and requesting |
| ref_req | output | 1 | Request for, or ownership of, the strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| addr_oe | output | 1 | Row address drive enable (RAS-only cycles) |
| row_addr | output | $clog2(ROWS) | Row address for RAS-only cycles |
| in_sr | output | 1 | Device is held in self-refresh |
| ready | output | 1 | Normal accesses may proceed |

## Verification
The bench builds the block with ROWS=4, INTERVAL=40, PEND_MAX=3, T_CSR=1, T_RAS=3, T_RP=2, T_RASS=5 and T_RPS=4. With four rows, the row counter wraps inside a short run of RAS-only cycles, and the full exit burst fits in a small capture window. An interval of 40 cycles is long enough for three made-up refreshes to finish before the next tick. It is also short enough for the cap on pending intervals to be reached within a few hundred cycles. The short entry and exit times let the bench count every strobe cycle exactly. That includes a wake pulse that lands in the middle of self-refresh entry.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CSR,
    ST_CBR,
    ST_ROW,
    ST_PRE,
    ST_SRENT,
    ST_SR,
    ST_SRX
  } ref_st_t;
endpackage

// File: rtl/ref_tick.sv
module ref_tick #(
  parameter int INTERVAL = 12500,
  parameter int PEND_MAX = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic take,
  output logic pend_nz
);
  localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam int PW = $clog2(PEND_MAX + 1);

  logic [CW-1:0] cnt;
  logic [PW-1:0] pend;
  logic          tick;

  assign tick    = (cnt == CW'(INTERVAL - 1));
  assign pend_nz = (pend != '0);

  always_ff @(posedge clk) begin
    if (!rst_n || hold) begin
      cnt  <= '0;
      pend <= '0;
    end else begin
      cnt <= tick ? '0 : cnt + 1'b1;
      if (tick && !take) begin
        if (pend != PW'(PEND_MAX)) pend <= pend + 1'b1;
      end else if (take && !tick) begin
        pend <= pend - 1'b1;
      end
    end
  end

  // R3
  pend_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == PW'(PEND_MAX) && !take && !hold) |=> (pend == PW'(PEND_MAX)));

  // R3
  take_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> pend_nz);
endmodule

// File: rtl/row_ctr.sv
module row_ctr #(
  parameter int ROWS = 1024,
  localparam int RW = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [RW-1:0] row
);
  always_ff @(posedge clk) begin
    if (!rst_n)    row <= '0;
    else if (adv)  row <= (row == RW'(ROWS - 1)) ? '0 : row + 1'b1;
  end
endmodule

// File: rtl/ref_seq.sv
module ref_seq
  import dram_ref_pkg::*;
#(
  parameter int ROWS   = 1024,
  parameter int T_CSR  = 1,
  parameter int T_RAS  = 6,
  parameter int T_RP   = 4,
  parameter int T_RASS = 10000,
  parameter int T_RPS  = 11000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pend_nz,
  input  logic ras_only,
  input  logic ref_gnt,
  input  logic sleep_req,
  input  logic wake_req,
  output logic ref_req,
  output logic take,
  output logic adv,
  output logic sr_busy,
  output logic ras_n,
  output logic cas_n,
  output logic addr_oe,
  output logic in_sr,
  output logic ready
);
  localparam int TA   = (T_CSR > T_RAS) ? T_CSR : T_RAS;
  localparam int TB   = (T_RP > TA) ? T_RP : TA;
  localparam int TC   = (T_RASS > T_RPS) ? T_RASS : T_RPS;
  localparam int TMAX = (TB > TC) ? TB : TC;
  localparam int PH_W = $clog2(TMAX + 1);
  localparam int BW   = $clog2(ROWS + 1);

  ref_st_t         st, st_nxt;
  logic [PH_W-1:0] ph, last;
  logic [BW-1:0]   burst_left;
  logic            sleep_pend, wake_pend, done, start;

  always_comb begin
    case (st)
      ST_CSR:          last = PH_W'(T_CSR - 1);
      ST_CBR, ST_ROW:  last = PH_W'(T_RAS - 1);
      ST_PRE:          last = PH_W'(T_RP - 1);
      ST_SRENT:        last = PH_W'(T_RASS - 1);
      ST_SRX:          last = PH_W'(T_RPS - 1);
      default:         last = '0;
    endcase
  end

  assign done    = (ph == last);
  assign sr_busy = (st == ST_SRENT) || (st == ST_SR) || (st == ST_SRX);
  assign ref_req = (st != ST_IDLE) || pend_nz || sleep_pend;
  assign start   = (st == ST_IDLE) && ref_req && ref_gnt;
  assign take    = start && !sleep_pend;
  assign adv     = (st == ST_ROW) && done;

  always_comb begin
    st_nxt = st;
    case (st)
      ST_IDLE:  if (start) st_nxt = (sleep_pend || !ras_only) ? ST_CSR : ST_ROW;
      ST_CSR:   if (done) st_nxt = sleep_pend ? ST_SRENT : ST_CBR;
      ST_CBR:   if (done) st_nxt = ST_PRE;
      ST_ROW:   if (done) st_nxt = ST_PRE;
      ST_PRE:   if (done) st_nxt = (burst_left > BW'(1)) ? ST_ROW : ST_IDLE;
      ST_SRENT: if (done) st_nxt = (wake_pend || wake_req) ? ST_SRX : ST_SR;
      ST_SR:    if (wake_req) st_nxt = ST_SRX;
      ST_SRX:   if (done) st_nxt = ras_only ? ST_ROW : ST_IDLE;
      default:  st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      ph         <= '0;
      burst_left <= '0;
      sleep_pend <= 1'b0;
      wake_pend  <= 1'b0;
    end else begin
      st <= st_nxt;
      if (st_nxt != st) ph <= '0;
      else if (!done)   ph <= ph + 1'b1;

      if (st == ST_SRX && done)
        burst_left <= ras_only ? BW'(ROWS) : '0;
      else if (st == ST_PRE && done && burst_left != '0)
        burst_left <= burst_left - 1'b1;

      if (st == ST_CSR && done && sleep_pend) sleep_pend <= 1'b0;
      else if (sleep_req && !sr_busy)         sleep_pend <= 1'b1;

      if (st == ST_SRX)                          wake_pend <= 1'b0;
      else if (st == ST_SRENT && wake_req)       wake_pend <= 1'b1;
    end
  end

  assign ras_n   = !((st == ST_CBR) || (st == ST_ROW) || (st == ST_SRENT) || (st == ST_SR));
  assign cas_n   = !((st == ST_CSR) || (st == ST_CBR) || (st == ST_SRENT) || (st == ST_SR));
  assign addr_oe = (st == ST_ROW);
  assign in_sr   = (st == ST_SR);
  assign ready   = !sr_busy && (burst_left == '0) && !(st == ST_CSR && sleep_pend);

  // R4
  no_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_req |=> (ras_n && cas_n));

  // R5
  cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !addr_oe) |-> !$past(cas_n));

  // R6
  ro_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_oe |-> (cas_n && !ras_n));

  // R8
  sr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_sr |-> (!ras_n && !cas_n && !ready));
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int ROWS     = 1024,
  parameter int INTERVAL = 12500,
  parameter int PEND_MAX = 4,
  parameter int T_CSR    = 1,
  parameter int T_RAS    = 6,
  parameter int T_RP     = 4,
  parameter int T_RASS   = 10000,
  parameter int T_RPS    = 11000,
  localparam int RW      = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ras_only,
  input  logic          sleep_req,
  input  logic          wake_req,
  input  logic          ref_gnt,
  output logic          ref_req,
  output logic          ras_n,
  output logic          cas_n,
  output logic          addr_oe,
  output logic [RW-1:0] row_addr,
  output logic          in_sr,
  output logic          ready
);
  logic pend_nz, take, adv, sr_busy;

  ref_tick #(.INTERVAL(INTERVAL), .PEND_MAX(PEND_MAX)) u_tick (
    .clk(clk), .rst_n(rst_n), .hold(sr_busy), .take(take), .pend_nz(pend_nz)
  );

  row_ctr #(.ROWS(ROWS)) u_row (
    .clk(clk), .rst_n(rst_n), .adv(adv), .row(row_addr)
  );

  ref_seq #(
    .ROWS(ROWS), .T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP),
    .T_RASS(T_RASS), .T_RPS(T_RPS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .pend_nz(pend_nz), .ras_only(ras_only),
    .ref_gnt(ref_gnt), .sleep_req(sleep_req), .wake_req(wake_req),
    .ref_req(ref_req), .take(take), .adv(adv), .sr_busy(sr_busy),
    .ras_n(ras_n), .cas_n(cas_n), .addr_oe(addr_oe), .in_sr(in_sr),
    .ready(ready)
  );
endmodule

// File: tb/test_dram_refresh_sched.sv
module test_dram_refresh_sched;
  localparam int ROWS = 4, INTERVAL = 40, PEND_MAX = 3;
  localparam int T_CSR = 1, T_RAS = 3, T_RP = 2, T_RASS = 5, T_RPS = 4;

  // each entry: {ras_only, expected row}
  localparam logic [2:0] VEC [0:6] = '{3'b000, 3'b100, 3'b101, 3'b000,
                                       3'b110, 3'b111, 3'b100};

  logic clk = 0, rst_n = 0, ras_only = 0, sleep_req = 0, wake_req = 0, ref_gnt = 0;
  logic ref_req, ras_n, cas_n, addr_oe, in_sr, ready;
  logic [1:0] row_addr;

  int tests = 0, fails = 0;
  bit done = 0;

  logic s_ras [0:63], s_cas [0:63], s_oe [0:63], s_sr [0:63], s_rdy [0:63], s_req [0:63];
  logic [1:0] s_row [0:63];

  always #5 clk = ~clk;

  dram_refresh_sched #(
    .ROWS(ROWS), .INTERVAL(INTERVAL), .PEND_MAX(PEND_MAX), .T_CSR(T_CSR),
    .T_RAS(T_RAS), .T_RP(T_RP), .T_RASS(T_RASS), .T_RPS(T_RPS)
  ) i_dram_refresh_sched (
    .clk(clk), .rst_n(rst_n), .ras_only(ras_only), .sleep_req(sleep_req),
    .wake_req(wake_req), .ref_gnt(ref_gnt), .ref_req(ref_req), .ras_n(ras_n),
    .cas_n(cas_n), .addr_oe(addr_oe), .row_addr(row_addr), .in_sr(in_sr),
    .ready(ready)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic capture(input int n);
    for (int i = 0; i < n; i++) begin
      s_ras[i] = ras_n; s_cas[i] = cas_n; s_oe[i] = addr_oe; s_sr[i] = in_sr;
      s_rdy[i] = ready; s_req[i] = ref_req; s_row[i] = row_addr;
      @(negedge clk);
    end
  endtask

  // wait for a request, check quiet strobes, grant for one cycle; returns at idx0
  task automatic give_grant();
    int w = 0;
    while (!ref_req && w < 200) begin @(negedge clk); w++; end
    chk(ref_req && ras_n && cas_n, "R4", "strobes quiet while request waits",
        {ref_req, ras_n, cas_n}, 3'b111);
    ref_gnt = 1;
    @(negedge clk);
    ref_gnt = 0;
  endtask

  task automatic pulse_sleep();
    sleep_req = 1; @(negedge clk); sleep_req = 0;
  endtask

  task automatic pulse_wake();
    wake_req = 1; @(negedge clk); wake_req = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n_ras, n_cas, n_oe, f_ras, f_cas, grants, pulses;
    logic [1:0] exp_row;
    bit ok;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ras_n && cas_n && !addr_oe && !ref_req && !in_sr && ready && row_addr == 0,
        "R1", "reset outputs", {ras_n, cas_n, addr_oe, ref_req, in_sr, ready}, 6'b110001);
    rst_n = 1;
    repeat (39) @(negedge clk);
    chk(!ref_req, "R2", "ref_req before interval", ref_req, 0);
    @(negedge clk);
    chk(ref_req, "R2", "ref_req at interval", ref_req, 1);

    // R3: no grant for three more intervals, pending saturates
    repeat (125) @(negedge clk);
    grants = 0;
    while (ref_req && grants < 10) begin
      give_grant();
      capture(6);
      grants++;
    end
    chk(grants == PEND_MAX, "R3", "made-up refresh count", grants, PEND_MAX);

    // table walk: R5 and R6
    for (int v = 0; v < 7; v++) begin
      ras_only = VEC[v][2];
      give_grant();
      capture(12);
      n_ras = 0; n_cas = 0; n_oe = 0; f_ras = -1; f_cas = -1; exp_row = 0;
      for (int i = 0; i < 12; i++) begin
        if (!s_ras[i]) begin n_ras++; if (f_ras < 0) begin f_ras = i; exp_row = s_row[i]; end end
        if (!s_cas[i]) begin n_cas++; if (f_cas < 0) f_cas = i; end
        if (s_oe[i]) n_oe++;
      end
      if (!VEC[v][2]) begin
        chk(n_cas == T_CSR + T_RAS && n_ras == T_RAS && f_ras - f_cas == T_CSR && n_oe == 0,
            "R5", "CAS-before-RAS cycle shape", n_ras * 100 + n_cas * 10 + n_oe, T_RAS * 100 + (T_CSR + T_RAS) * 10);
      end else begin
        chk(n_cas == 0 && n_ras == T_RAS && n_oe == T_RAS, "R6", "RAS-only cycle shape",
            n_ras * 100 + n_cas * 10 + n_oe, T_RAS * 100 + T_RAS);
        chk(exp_row == VEC[v][1:0], "R6", "RAS-only row address", exp_row, VEC[v][1:0]);
      end
    end

    // R11: wake outside self-refresh ignored
    ras_only = 0;
    pulse_wake();
    capture(4);
    ok = 1;
    for (int i = 0; i < 4; i++) if (s_sr[i] || !s_rdy[i] || !s_ras[i]) ok = 0;
    chk(ok, "R11", "stray wake has no effect", ok, 1);

    // R7/R8/R9/R10: self-refresh in CAS-before-RAS mode
    pulse_sleep();
    give_grant();
    capture(7);
    chk(!s_cas[0] && s_ras[0] && !s_ras[1], "R7", "entry strobe order",
        {s_cas[0], s_ras[0], s_ras[1]}, 3'b010);
    chk(!s_sr[5] && s_sr[6], "R7", "in_sr after entry time", {s_sr[5], s_sr[6]}, 2'b01);
    chk(!s_rdy[1], "R7", "ready low during entry", s_rdy[1], 0);
    pulse_sleep();
    ok = 1;
    for (int i = 0; i < 100; i++) begin
      if (ras_n || cas_n || !in_sr || addr_oe) ok = 0;
      @(negedge clk);
    end
    chk(ok, "R8", "strobes held low in self-refresh", ok, 1);
    pulse_wake();
    capture(45);
    chk(s_ras[0] && s_cas[0] && !s_sr[0], "R9", "strobes released on wake",
        {s_ras[0], s_cas[0], s_sr[0]}, 3'b110);
    chk(!s_rdy[3] && s_rdy[4], "R9", "ready after exit time", {s_rdy[3], s_rdy[4]}, 2'b01);
    ok = 1;
    for (int i = 0; i < 44; i++) if (!s_ras[i] || !s_cas[i]) ok = 0;
    chk(ok, "R10", "no burst after exit in CAS-before-RAS mode", ok, 1);
    ok = 1;
    for (int i = 4; i < 44; i++) if (s_req[i]) ok = 0;
    chk(ok, "R11", "sleep during self-refresh ignored, no request", ok, 1);
    chk(s_req[44], "R10", "timer restarted after exit", s_req[44], 1);

    // R8: wake during entry is deferred
    pulse_sleep();
    give_grant();
    n_ras = 0; ok = 0;
    for (int i = 0; i < 16; i++) begin
      if (!ras_n) n_ras++;
      if (in_sr) ok = 1;
      s_rdy[i] = ready;
      wake_req = (i == 2);
      @(negedge clk);
    end
    wake_req = 0;
    chk(n_ras == T_RASS && !ok, "R8", "early wake keeps minimum entry time", n_ras, T_RASS);
    chk(!s_rdy[9] && s_rdy[10], "R9", "early wake exit time", {s_rdy[9], s_rdy[10]}, 2'b01);

    // R10/R6: self-refresh exit burst in RAS-only mode
    ras_only = 1;
    pulse_sleep();
    give_grant();
    capture(7);
    repeat (3) @(negedge clk);
    pulse_wake();
    capture(26);
    pulses = 0; ok = 1; exp_row = 2'd1;
    for (int i = 0; i < 26; i++) begin
      if (!s_cas[i]) ok = 0;
      if (s_oe[i] && (i == 0 || !s_oe[i-1])) begin
        if (s_row[i] != exp_row) ok = 0;
        exp_row = exp_row + 2'd1;
        pulses++;
      end
    end
    chk(pulses == ROWS, "R10", "burst covers every row", pulses, ROWS);
    chk(ok, "R6", "burst rows in counter order with cas_n high", ok, 1);
    chk(!s_rdy[23] && s_rdy[24], "R10", "ready after burst", {s_rdy[23], s_rdy[24]}, 2'b01);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule